// File: doc/BRIEF.md
# Root Port Error Collector

This block sits in a root port and takes in the error messages that reach it from below. Each message carries a severity code and a 16-bit requester identity. The block keeps the root error status flags and two identity registers. One holds the first correctable source and the other the first uncorrectable source. It decides whether software has to be told. If so, it raises the interrupt in one of three ways: a one-cycle MSI-X pulse, a one-cycle MSI pulse with a vector number, or a level on INTA.

Software programs a three-bit root command register with one enable bit per severity class. It clears received flags by writing ones to them. Messages arrive on a valid/ready stream. The block accepts a message on any rising edge where `msg_valid` and `msg_ready` are both high. `msg_ready` is low only in a cycle where a status clear is being applied, so a clear and a message never land on the same edge. A sender must hold the message stable until it is accepted.

Top module: `rp_err_collector`

## Requirements
- R1: After reset, the root command register, every status flag, both source registers and every interrupt output are zero. A later reset clears a non-zero root command register again.
- R2: A correctable message (severity code 1) accepted while the correctable-received flag (status bit 0) is clear stores its source in `cor_src` and sets bit 0. If command bit 0 is set, it also requests a message interrupt.
- R3: A correctable message accepted while status bit 0 is set only sets the multiple-correctable flag (status bit 3). `cor_src` keeps its value and no interrupt is requested.
- R4: A non-fatal message (code 2) sets status bit 1. It requests a message interrupt only if bit 1 was clear and command bit 1 is set.
- R5: A fatal message (code 4) sets status bit 2. It requests a message interrupt only if bit 2 was clear and command bit 2 is set. It sets the first-is-fatal flag (status bit 6) only if the uncorrectable-received flag (status bit 4) was clear.
- R6: A non-fatal or fatal message sets status bit 4. If bit 4 was clear, the message source goes into `unc_src`. Otherwise `unc_src` is held and the multiple-uncorrectable flag (status bit 5) is set.
- R7: A root command write requests a message interrupt if some enable bit goes from 0 to 1 while the matching received flag (status bits 2:0) is set. Rewriting an enable that is already set requests nothing.
- R8: A requested interrupt appears in the cycle after acceptance or write. It is an `msix_pulse` when `msix_en` is set, otherwise an `msi_pulse` when `msi_en` is set. Along with the pulse, `irq_vector` carries the `vec_num` value.
- R9: When neither MSI-X nor MSI is enabled, `inta_level` is the OR over the three classes of (command bit AND received flag). It is always low when either message mode is enabled.
- R10: A status clear writes ones in `sts_clr_mask` to clear the matching status bits. During the clear cycle `msg_ready` is low.
- R11: A message with any other severity code is accepted but changes no status, source or interrupt output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msg_valid | input | 1 | Error message present |
| msg_ready | output | 1 | Message can be accepted this cycle |
| msg_sev | input | 3 | Severity code: 1 correctable, 2 non-fatal, 4 fatal |
| msg_src | input | 16 | Requester identity of the message |
| cmd_wr_en | input | 1 | Write root command register |
| cmd_wr_data | input | 3 | New enables: bit0 correctable, bit1 non-fatal, bit2 fatal |
| sts_clr_en | input | 1 | Apply write-1-to-clear to status |
| sts_clr_mask | input | 7 | Status bits to clear |
| msix_en | input | 1 | MSI-X delivery enabled |
| msi_en | input | 1 | MSI delivery enabled |
| vec_num | input | 5 | Interrupt message number from the status register field |
| root_cmd | output | 3 | Root command enables |
| root_status | output | 7 | Status flags, bit positions per R2 to R6 |
| cor_src | output | 16 | First correctable source |
| unc_src | output | 16 | First uncorrectable source |
| msix_pulse | output | 1 | One-cycle MSI-X request |
| msi_pulse | output | 1 | One-cycle MSI request |
| irq_vector | output | 5 | Vector sent with the pulse |
| inta_level | output | 1 | Legacy interrupt level |

## Verification
The bench sweeps every command value and every ordered pair of severity codes, including an illegal one, under each of the three delivery modes. After each pair it writes the inverted command. One corner case is a repeated message of the same class: a design that re-fires on it would show an extra pulse, and one that overwrites the source register would show the later identity. Another is a fatal message after a non-fatal one. Here the first-is-fatal flag must stay clear while a fresh fatal interrupt is still owed, and a design sharing one first-occurrence flag across classes would drop that pulse. The command write after each pair checks that only 0-to-1 enables with a pending flag fire, and that INTA follows the new enables at once.

// File: rtl/rpec_pkg.sv
package rpec_pkg;
  localparam int SEV_W = 3;
  localparam int ST_W  = 7;

  localparam logic [SEV_W-1:0] SEV_COR = 3'd1;
  localparam logic [SEV_W-1:0] SEV_NF  = 3'd2;
  localparam logic [SEV_W-1:0] SEV_FAT = 3'd4;

  // status bit positions; bits 2:0 line up with the command enables
  localparam int B_COR       = 0;
  localparam int B_NF        = 1;
  localparam int B_FAT       = 2;
  localparam int B_COR_MULTI = 3;
  localparam int B_UNC       = 4;
  localparam int B_UNC_MULTI = 5;
  localparam int B_FIRST_FAT = 6;
endpackage

// File: rtl/rpec_status_log.sv
module rpec_status_log
  import rpec_pkg::*;
#(
  parameter int SRC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  logic [SEV_W-1:0] sev,
  input  logic [SRC_W-1:0] src,
  input  logic             clr_en,
  input  logic [ST_W-1:0]  clr_mask,
  input  logic [SEV_W-1:0] cmd,
  output logic [ST_W-1:0]  status,
  output logic [SRC_W-1:0] cor_src,
  output logic [SRC_W-1:0] unc_src,
  output logic             msg_req
);
  logic [ST_W-1:0]  st_nxt;
  logic [SRC_W-1:0] cor_nxt, unc_nxt;
  logic             is_unc;

  always_comb begin
    st_nxt  = status;
    cor_nxt = cor_src;
    unc_nxt = unc_src;
    msg_req = 1'b0;
    is_unc  = 1'b0;
    if (fire) begin
      case (sev)
        SEV_COR: begin
          if (status[B_COR]) st_nxt[B_COR_MULTI] = 1'b1;
          else begin
            cor_nxt = src;
            msg_req = cmd[B_COR];
          end
          st_nxt[B_COR] = 1'b1;
        end
        SEV_NF: begin
          msg_req      = !status[B_NF] && cmd[B_NF];
          st_nxt[B_NF] = 1'b1;
          is_unc       = 1'b1;
        end
        SEV_FAT: begin
          msg_req = !status[B_FAT] && cmd[B_FAT];
          if (!status[B_UNC]) st_nxt[B_FIRST_FAT] = 1'b1;
          st_nxt[B_FAT] = 1'b1;
          is_unc        = 1'b1;
        end
        default: ;
      endcase
      if (is_unc) begin
        if (status[B_UNC]) st_nxt[B_UNC_MULTI] = 1'b1;
        else unc_nxt = src;
        st_nxt[B_UNC] = 1'b1;
      end
    end
    if (clr_en) st_nxt = st_nxt & ~clr_mask;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status  <= '0;
      cor_src <= '0;
      unc_src <= '0;
    end else begin
      status  <= st_nxt;
      cor_src <= cor_nxt;
      unc_src <= unc_nxt;
    end
  end
endmodule

// File: rtl/rpec_cmd_reg.sv
module rpec_cmd_reg
  import rpec_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SEV_W-1:0] wr_data,
  input  logic [SEV_W-1:0] rcv,
  output logic [SEV_W-1:0] cmd,
  output logic             wr_req
);
  logic [SEV_W-1:0] rising;

  assign rising = wr_data & ~cmd;
  assign wr_req = wr_en && |(rising & rcv);

  always_ff @(posedge clk) begin
    if (!rst_n)     cmd <= '0;
    else if (wr_en) cmd <= wr_data;
  end
endmodule

// File: rtl/rpec_notify.sv
module rpec_notify
  import rpec_pkg::*;
#(
  parameter int VEC_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic             msix_en,
  input  logic             msi_en,
  input  logic [VEC_W-1:0] vec_num,
  input  logic [SEV_W-1:0] cmd,
  input  logic [SEV_W-1:0] rcv,
  output logic             msix_pulse,
  output logic             msi_pulse,
  output logic [VEC_W-1:0] vector,
  output logic             inta
);
  logic [SEV_W-1:0] live;

  for (genvar g = 0; g < SEV_W; g++) begin : g_cls
    assign live[g] = cmd[g] & rcv[g];
  end

  assign inta = !msix_en && !msi_en && (|live);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      msix_pulse <= 1'b0;
      msi_pulse  <= 1'b0;
      vector     <= '0;
    end else begin
      msix_pulse <= req && msix_en;
      msi_pulse  <= req && !msix_en && msi_en;
      if (req) vector <= vec_num;
    end
  end
endmodule

// File: rtl/rp_err_collector.sv
module rp_err_collector
  import rpec_pkg::*;
#(
  parameter int SRC_W = 16,
  parameter int VEC_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             msg_valid,
  output logic             msg_ready,
  input  logic [2:0]       msg_sev,
  input  logic [SRC_W-1:0] msg_src,
  input  logic             cmd_wr_en,
  input  logic [2:0]       cmd_wr_data,
  input  logic             sts_clr_en,
  input  logic [6:0]       sts_clr_mask,
  input  logic             msix_en,
  input  logic             msi_en,
  input  logic [VEC_W-1:0] vec_num,
  output logic [2:0]       root_cmd,
  output logic [6:0]       root_status,
  output logic [SRC_W-1:0] cor_src,
  output logic [SRC_W-1:0] unc_src,
  output logic             msix_pulse,
  output logic             msi_pulse,
  output logic [VEC_W-1:0] irq_vector,
  output logic             inta_level
);
  logic fire, msg_req, wr_req;

  assign msg_ready = !sts_clr_en;
  assign fire      = msg_valid && msg_ready;

  rpec_status_log #(.SRC_W(SRC_W)) u_log (
    .clk(clk), .rst_n(rst_n), .fire(fire), .sev(msg_sev), .src(msg_src),
    .clr_en(sts_clr_en), .clr_mask(sts_clr_mask), .cmd(root_cmd),
    .status(root_status), .cor_src(cor_src), .unc_src(unc_src),
    .msg_req(msg_req)
  );

  rpec_cmd_reg u_cmd (
    .clk(clk), .rst_n(rst_n), .wr_en(cmd_wr_en), .wr_data(cmd_wr_data),
    .rcv(root_status[B_FAT:B_COR]), .cmd(root_cmd), .wr_req(wr_req)
  );

  rpec_notify #(.VEC_W(VEC_W)) u_ntf (
    .clk(clk), .rst_n(rst_n), .req(msg_req || wr_req), .msix_en(msix_en),
    .msi_en(msi_en), .vec_num(vec_num), .cmd(root_cmd),
    .rcv(root_status[B_FAT:B_COR]), .msix_pulse(msix_pulse),
    .msi_pulse(msi_pulse), .vector(irq_vector), .inta(inta_level)
  );
endmodule

// File: rtl/rp_err_collector_chk.sv
module rp_err_collector_chk #(
  parameter int SRC_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             msg_valid,
  input logic             msg_ready,
  input logic [2:0]       msg_sev,
  input logic [6:0]       root_status,
  input logic [SRC_W-1:0] cor_src,
  input logic [SRC_W-1:0] unc_src,
  input logic             msix_pulse,
  input logic             msi_pulse
);
  logic acc;
  assign acc = msg_valid && msg_ready;

  p_pulse_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(msix_pulse && msi_pulse));

  p_multi_cor_r3: assert property (@(posedge clk) disable iff (!rst_n)
    acc && msg_sev == 3'd1 && root_status[0] |=> root_status[3]);

  p_cor_src_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    acc && msg_sev == 3'd1 && root_status[0] |=> $stable(cor_src));

  p_first_fatal_r5: assert property (@(posedge clk) disable iff (!rst_n)
    acc && msg_sev == 3'd4 && !root_status[4] |=> root_status[6]);

  p_unc_src_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    acc && (msg_sev == 3'd2 || msg_sev == 3'd4) && root_status[4]
    |=> $stable(unc_src) && root_status[5]);
endmodule

bind rp_err_collector rp_err_collector_chk #(.SRC_W(SRC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_ready(msg_ready),
  .msg_sev(msg_sev), .root_status(root_status), .cor_src(cor_src),
  .unc_src(unc_src), .msix_pulse(msix_pulse), .msi_pulse(msi_pulse)
);

// File: tb/test_rp_err_collector.sv
module test_rp_err_collector;
  logic clk = 1'b0, rst_n = 1'b0;
  logic msg_valid = 1'b0, msg_ready;
  logic [2:0] msg_sev = '0;
  logic [15:0] msg_src = '0;
  logic cmd_wr_en = 1'b0;
  logic [2:0] cmd_wr_data = '0;
  logic sts_clr_en = 1'b0;
  logic [6:0] sts_clr_mask = '0;
  logic msix_en = 1'b0, msi_en = 1'b0;
  logic [4:0] vec_num = '0;
  logic [2:0] root_cmd;
  logic [6:0] root_status;
  logic [15:0] cor_src, unc_src;
  logic msix_pulse, msi_pulse, inta_level;
  logic [4:0] irq_vector;

  int n_chk = 0, n_fail = 0, cyc = 0;
  logic [6:0] e_st;
  logic [15:0] e_cor, e_unc;
  logic [2:0] e_cmd;
  logic e_req;

  always #5 clk = ~clk;

  rp_err_collector i_rp_err_collector (.*);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_fail = n_fail + 1;
      n_chk = n_chk + 1;
      $display("FAIL watchdog: run did not finish, act %0d exp below 150000", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: act %h exp %h", tag, act, exp);
    end
  endtask

  // outputs sampled one negedge after the accepting edge
  task automatic chk_all(input string tag);
    chk({tag, " status"}, 32'(root_status), 32'(e_st));
    chk({tag, " cor_src"}, 32'(cor_src), 32'(e_cor));
    chk({tag, " unc_src"}, 32'(unc_src), 32'(e_unc));
    chk("R8 msix pulse", 32'(msix_pulse), 32'(e_req && msix_en));
    chk("R8 msi pulse", 32'(msi_pulse), 32'(e_req && !msix_en && msi_en));
    if (e_req) chk("R8 vector", 32'(irq_vector), 32'(vec_num));
    chk("R9 inta", 32'(inta_level), 32'(!msix_en && !msi_en && |(e_cmd & e_st[2:0])));
  endtask

  task automatic send(input logic [2:0] sev, input logic [15:0] src);
    e_req = 1'b0;
    case (sev)
      3'd1: begin
        if (e_st[0]) e_st[3] = 1'b1;
        else begin e_cor = src; e_req = e_cmd[0]; end
        e_st[0] = 1'b1;
      end
      3'd2, 3'd4: begin
        if (sev == 3'd2) begin e_req = !e_st[1] && e_cmd[1]; e_st[1] = 1'b1; end
        else begin
          e_req = !e_st[2] && e_cmd[2];
          if (!e_st[4]) e_st[6] = 1'b1;
          e_st[2] = 1'b1;
        end
        if (e_st[4]) e_st[5] = 1'b1; else e_unc = src;
        e_st[4] = 1'b1;
      end
      default: ;
    endcase
    @(negedge clk);
    msg_valid = 1'b1; msg_sev = sev; msg_src = src;
    @(negedge clk);
    msg_valid = 1'b0;
    case (sev)
      3'd1: chk_all("R2/R3 cor");
      3'd2: chk_all("R4/R6 nonfatal");
      3'd4: chk_all("R5/R6 fatal");
      default: chk_all("R11 illegal code");
    endcase
  endtask

  task automatic wr_cmd(input logic [2:0] d);
    e_req = |(d & ~e_cmd & e_st[2:0]);
    e_cmd = d;
    @(negedge clk);
    cmd_wr_en = 1'b1; cmd_wr_data = d;
    @(negedge clk);
    cmd_wr_en = 1'b0;
    chk("R7 cmd", 32'(root_cmd), 32'(d));
    chk_all("R7 cmd write");
  endtask

  task automatic clr(input logic [6:0] m);
    e_st = e_st & ~m;
    e_req = 1'b0;
    @(negedge clk);
    sts_clr_en = 1'b1; sts_clr_mask = m;
    #1 chk("R10 ready low during clear", 32'(msg_ready), 32'd0);
    @(negedge clk);
    sts_clr_en = 1'b0;
    chk_all("R10 clear");
  endtask

  initial begin
    logic [2:0] codes [4];
    codes[0] = 3'd1; codes[1] = 3'd2; codes[2] = 3'd4; codes[3] = 3'd3;
    e_st = '0; e_cor = '0; e_unc = '0; e_cmd = '0; e_req = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset cmd", 32'(root_cmd), 32'd0);
    chk_all("R1 reset");
    chk("R1 ready", 32'(msg_ready), 32'd1);

    for (int m = 0; m < 3; m++) begin
      for (int c = 0; c < 8; c++) begin
        for (int a = 0; a < 4; a++) begin
          for (int b = 0; b < 4; b++) begin
            msix_en = (m == 2); msi_en = (m == 1);
            vec_num = 5'(c * 4 + a + b);
            clr(7'h7F);
            wr_cmd(3'(c));
            send(codes[a], 16'(16'h1000 + m * 512 + c * 16 + a * 4 + b));
            send(codes[b], 16'(16'h8000 + m * 512 + c * 16 + a * 4 + b));
            wr_cmd(3'(~c));
            clr(7'h55);
          end
        end
      end
    end

    // R1: reset clears a programmed command register
    wr_cmd(3'b101);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    chk("R1 cmd after reset", 32'(root_cmd), 32'd0);
    chk("R1 status after reset", 32'(root_status), 32'd0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule